// File: doc/BRIEF.md
# Page-Walk Memory Request Scheduler

This block sits between the decode state machine of a page-table walker and a memory port that may turn requests away. It keeps one slot for the next table read and a four-entry last-in first-out stack for entry write-backs, which are the updated entries going back to memory. Each cycle it offers at most one request on a valid/ready channel. A pending read always goes first. Write-backs then go out one per cycle, newest first, for as long as the port accepts them.

When the port rejects a request, the request stays where it was and the scheduler freezes. It offers nothing more until the memory side pulses a retry input. A response marked as a negative acknowledge is offered again in the same cycle, ahead of everything else. If that resend is also rejected, the request goes back to the read slot or onto the stack, and the scheduler freezes. Read responses are passed to the walker, which may enqueue a follow-on read and a write-back in the same cycle.

The walk ends when nothing is outstanding, no read is pending and the stack is empty. At that point a one-cycle completion pulse is raised, together with any fault the walker reported during the walk.

Top module: `pws_walk_sched`

## Requirements
- R1: During and right after reset, `mreq_valid`, `done`, `done_fault` and `wb_overflow` are all 0.
- R2: When not frozen and no negative acknowledge is present, a pending read is offered (`mreq_we`=0) before any queued write-back.
- R3: Queued write-backs are offered newest first, one per cycle, back to back while the port accepts them, carrying their address and data unchanged.
- R4: A request offered while `mreq_ready` is 0 is rejected and kept pending. From the next cycle nothing is offered until a `mreq_retry` pulse, and the cycle after that pulse reissues the kept request first.
- R5: An outstanding count rises on each accepted new request and falls on each normal response. `done` stays 0 while it is nonzero.
- R6: A response with `rsp_nack`=1 is offered again on the request channel in the same cycle, with its address, direction, data and size, even while frozen. An accepted resend leaves the outstanding count unchanged.
- R7: A resend that is rejected lowers the outstanding count. A read returns to the read slot and a write-back returns to the top of the stack, and the block freezes as in R4.
- R8: A normal read response (`rsp_we`=0) raises `wk_rsp_valid` in the same cycle with `wk_rsp_data` equal to `rsp_data`. Write responses and negative acknowledges do not.
- R9: `done` pulses for exactly one cycle once the walk has drained. `done_fault` is 1 in that cycle only if `wk_fault` was seen with a read response during that walk. The fault record is then cleared.
- R10: The stack holds 4 entries. A push onto a full stack with no pop in the same cycle raises `wb_overflow` for that cycle and leaves the stored entries untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_enq_valid | input | 1 | Walker places the next table read |
| rd_enq_addr | input | 52 | Physical address of that read |
| rd_enq_size | input | 4 | Access size in bytes |
| wr_enq_valid | input | 1 | Walker pushes an entry write-back |
| wr_enq_addr | input | 52 | Write-back address |
| wr_enq_data | input | 64 | Updated entry value |
| wr_enq_size | input | 4 | Write-back size in bytes |
| wk_fault | input | 1 | Walker reports a fault with the current read response |
| wk_rsp_valid | output | 1 | Read data forwarded to the walker |
| wk_rsp_data | output | 64 | Forwarded read data |
| mreq_valid | output | 1 | Request offered to memory |
| mreq_ready | input | 1 | Memory accepts the offered request |
| mreq_addr | output | 52 | Request address |
| mreq_we | output | 1 | 1 for a write-back, 0 for a read |
| mreq_data | output | 64 | Write data |
| mreq_size | output | 4 | Request size in bytes |
| mreq_retry | input | 1 | Memory invites a new attempt after a rejection |
| rsp_valid | input | 1 | Response arrives |
| rsp_nack | input | 1 | Response is a negative acknowledge |
| rsp_we | input | 1 | Response belongs to a write-back |
| rsp_addr | input | 52 | Address of the answered request |
| rsp_data | input | 64 | Read data, or write data of a refused write |
| rsp_size | input | 4 | Size of the answered request |
| done | output | 1 | One-cycle walk completion pulse |
| done_fault | output | 1 | Walk ended with a recorded fault |
| wb_overflow | output | 1 | Write-back pushed onto a full stack |

## Verification
The properties assume a well-behaved walker. It enqueues a read only into an empty slot, and it never pushes a write-back in a cycle that carries a negative acknowledge. Follow-on work is enqueued in the same cycle as the read response that caused it. Memory is assumed to answer only requests it has accepted. The stimulus follows these rules by acting as walker and memory in one directed sequence. It pushes write-backs only while a rejected read holds the walk open, or alongside a read response, and it raises retry only after a rejection.

// File: rtl/pws_pkg.sv
package pws_pkg;

  parameter int unsigned PA_W   = 52;
  parameter int unsigned DATA_W = 64;
  parameter int unsigned SZ_W   = 4;

  typedef struct packed {
    logic [PA_W-1:0]   addr;
    logic [DATA_W-1:0] data;
    logic [SZ_W-1:0]   size;
  } pws_req_t;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NACK = 2'd1,
    SRC_READ = 2'd2,
    SRC_WB   = 2'd3
  } pws_src_e;

  // Fixed priority: a refused response's resend, then the read slot, then the stack.
  function automatic pws_src_e pick_src(logic nack, logic frozen, logic rd_pend,
                                        logic wb_avail);
    if (nack)                  return SRC_NACK;
    if (!frozen && rd_pend)    return SRC_READ;
    if (!frozen && wb_avail)   return SRC_WB;
    return SRC_NONE;
  endfunction

endpackage

// File: rtl/pws_issue_sel.sv
module pws_issue_sel
  import pws_pkg::*;
(
  input  logic     nack_now,
  input  logic     frozen,
  input  logic     rd_pend,
  input  logic     wb_avail,
  output pws_src_e src
);

  assign src = pick_src(nack_now, frozen, rd_pend, wb_avail);

endmodule

// File: rtl/pws_out_ctr.sv
module pws_out_ctr #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count
);

  function automatic logic [CW-1:0] step_count(logic [CW-1:0] c, logic up, logic down);
    case ({up, down})
      2'b10:   return c + CW'(1);
      2'b01:   return c - CW'(1);
      default: return c;
    endcase
  endfunction

  logic [CW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= step_count(count_q, inc, dec);
  end

  assign count = count_q;

endmodule

// File: rtl/pws_wb_stack.sv
module pws_wb_stack #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned EW    = 8,
  parameter int unsigned SPW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [EW-1:0]  push_ent,
  input  logic           pop,
  output logic [EW-1:0]  top_ent,
  output logic [SPW-1:0] count,
  output logic           empty,
  output logic           overflow
);

  logic [EW-1:0]    mem_q [DEPTH];
  logic [SPW-1:0]   cnt_q;
  logic             full;
  logic             push_ok;
  logic [SPW-1:0]   wr_pos;
  logic [DEPTH-1:0] slot_we;

  assign full     = (cnt_q == SPW'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign push_ok  = push && (pop || !full);
  assign overflow = push && full && !pop;
  assign wr_pos   = pop ? cnt_q - SPW'(1) : cnt_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign slot_we[g] = push_ok && (wr_pos == SPW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (slot_we[i]) mem_q[i] <= push_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + SPW'(push_ok) - SPW'(pop && !empty);
  end

  always_comb begin
    top_ent = '0;
    for (int i = 0; i < DEPTH; i++)
      if (!empty && (cnt_q - SPW'(1)) == SPW'(i)) top_ent = mem_q[i];
  end

  assign count = cnt_q;

endmodule

// File: rtl/pws_walk_sched.sv
module pws_walk_sched
  import pws_pkg::*;
#(
  parameter int unsigned WB_DEPTH = 4,
  parameter int unsigned MAX_OUT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_enq_valid,
  input  logic [PA_W-1:0]   rd_enq_addr,
  input  logic [SZ_W-1:0]   rd_enq_size,
  input  logic              wr_enq_valid,
  input  logic [PA_W-1:0]   wr_enq_addr,
  input  logic [DATA_W-1:0] wr_enq_data,
  input  logic [SZ_W-1:0]   wr_enq_size,
  input  logic              wk_fault,
  output logic              wk_rsp_valid,
  output logic [DATA_W-1:0] wk_rsp_data,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [PA_W-1:0]   mreq_addr,
  output logic              mreq_we,
  output logic [DATA_W-1:0] mreq_data,
  output logic [SZ_W-1:0]   mreq_size,
  input  logic              mreq_retry,
  input  logic              rsp_valid,
  input  logic              rsp_nack,
  input  logic              rsp_we,
  input  logic [PA_W-1:0]   rsp_addr,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [SZ_W-1:0]   rsp_size,
  output logic              done,
  output logic              done_fault,
  output logic              wb_overflow
);

  localparam int unsigned CW  = $clog2(MAX_OUT + 1);
  localparam int unsigned SPW = $clog2(WB_DEPTH + 1);
  localparam int unsigned EW  = $bits(pws_req_t);

  // State
  logic     rd_pend_q;
  pws_req_t rd_slot_q;
  logic     retry_q;
  logic     busy_q;
  logic     fault_q;

  // Named events
  logic     ev_nack, ev_rsp_ok, ev_accept, ev_reject, ev_nack_back;
  logic     wb_push, wb_pop, wb_empty;
  logic [SPW-1:0] wb_cnt;
  logic [CW-1:0]  out_cnt;
  pws_src_e src;
  pws_req_t nack_req, wr_req, push_req, wb_top, issue_req;
  logic [EW-1:0]  wb_top_vec;

  assign nack_req  = '{addr: rsp_addr, data: rsp_data, size: rsp_size};
  assign wr_req    = '{addr: wr_enq_addr, data: wr_enq_data, size: wr_enq_size};
  assign ev_nack   = rsp_valid && rsp_nack;
  assign ev_rsp_ok = rsp_valid && !rsp_nack;

  pws_issue_sel u_sel (
    .nack_now (ev_nack),
    .frozen   (retry_q),
    .rd_pend  (rd_pend_q),
    .wb_avail (!wb_empty),
    .src      (src)
  );

  always_comb begin
    issue_req = '0;
    mreq_we   = 1'b0;
    case (src)
      SRC_NACK: begin issue_req = nack_req;  mreq_we = rsp_we; end
      SRC_READ: begin issue_req = rd_slot_q; mreq_we = 1'b0;   end
      SRC_WB:   begin issue_req = wb_top;    mreq_we = 1'b1;   end
      default:  begin issue_req = '0;        mreq_we = 1'b0;   end
    endcase
  end

  assign mreq_valid = (src != SRC_NONE);
  assign mreq_addr  = issue_req.addr;
  assign mreq_data  = issue_req.data;
  assign mreq_size  = issue_req.size;

  assign ev_accept    = mreq_valid && mreq_ready;
  assign ev_reject    = mreq_valid && !mreq_ready;
  assign ev_nack_back = ev_nack && ev_reject;

  // Outstanding requests
  pws_out_ctr #(.CW(CW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (ev_accept && (src != SRC_NACK)),
    .dec   (ev_rsp_ok || ev_nack_back),
    .count (out_cnt)
  );

  // Write-back stack
  assign wb_pop   = ev_accept && (src == SRC_WB);
  assign wb_push  = wr_enq_valid || (ev_nack_back && rsp_we);
  assign push_req = (ev_nack_back && rsp_we) ? nack_req : wr_req;
  assign wb_top   = pws_req_t'(wb_top_vec);

  pws_wb_stack #(.DEPTH(WB_DEPTH), .EW(EW), .SPW(SPW)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (wb_push),
    .push_ent (push_req),
    .pop      (wb_pop),
    .top_ent  (wb_top_vec),
    .count    (wb_cnt),
    .empty    (wb_empty),
    .overflow (wb_overflow)
  );

  // Read slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_slot_q <= '0;
    end else if (ev_nack_back && !rsp_we) begin
      rd_pend_q <= 1'b1;
      rd_slot_q <= nack_req;
    end else if (rd_enq_valid) begin
      rd_pend_q <= 1'b1;
      rd_slot_q <= '{addr: rd_enq_addr, data: '0, size: rd_enq_size};
    end else if (ev_accept && (src == SRC_READ)) begin
      rd_pend_q <= 1'b0;
    end
  end

  // Freeze after a rejection until the memory invites a retry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          retry_q <= 1'b0;
    else if (ev_reject)  retry_q <= 1'b1;
    else if (mreq_retry) retry_q <= 1'b0;
  end

  // Walk completion
  assign done       = busy_q && (out_cnt == '0) && !rd_pend_q && wb_empty;
  assign done_fault = done && fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      if (done)              busy_q <= 1'b0;
      else if (rd_enq_valid) busy_q <= 1'b1;
      if (done)                           fault_q <= 1'b0;
      else if (wk_rsp_valid && wk_fault)  fault_q <= 1'b1;
    end
  end

  assign wk_rsp_valid = ev_rsp_ok && !rsp_we;
  assign wk_rsp_data  = rsp_data;

endmodule

// File: rtl/pws_walk_sched_chk.sv
module pws_walk_sched_chk
  import pws_pkg::*;
#(
  parameter int unsigned WB_DEPTH = 4,
  parameter int unsigned CW       = 4,
  parameter int unsigned SPW      = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mreq_valid,
  input logic            mreq_we,
  input logic [PA_W-1:0] mreq_addr,
  input logic            rsp_valid,
  input logic            rsp_we,
  input logic [PA_W-1:0] rsp_addr,
  input logic            ev_nack,
  input logic            ev_accept,
  input logic            ev_reject,
  input logic            rd_pend,
  input logic [PA_W-1:0] rd_addr,
  input logic            retry,
  input logic [CW-1:0]   out_cnt,
  input logic [SPW-1:0]  wb_cnt,
  input logic            wb_overflow,
  input logic            done
);

  // R2
  rd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !ev_nack && rd_pend |-> !mreq_we);

  // R4
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry && !ev_nack |-> !mreq_valid);

  // R4
  keep_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject && !ev_nack && !mreq_we |=> rd_pend && retry && (rd_addr == $past(mreq_addr)));

  // R5
  cnt_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && !ev_nack && !rsp_valid |=> out_cnt == CW'($past(out_cnt) + 1'b1));

  // R6
  nack_resend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nack |-> mreq_valid && (mreq_addr == rsp_addr) && (mreq_we == rsp_we));

  // R7
  nack_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nack && ev_reject |=> retry && (out_cnt == CW'($past(out_cnt) - 1'b1)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_overflow |=> wb_cnt == SPW'(WB_DEPTH));

endmodule

bind pws_walk_sched pws_walk_sched_chk #(.WB_DEPTH(WB_DEPTH), .CW(CW), .SPW(SPW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mreq_valid  (mreq_valid),
  .mreq_we     (mreq_we),
  .mreq_addr   (mreq_addr),
  .rsp_valid   (rsp_valid),
  .rsp_we      (rsp_we),
  .rsp_addr    (rsp_addr),
  .ev_nack     (ev_nack),
  .ev_accept   (ev_accept),
  .ev_reject   (ev_reject),
  .rd_pend     (rd_pend_q),
  .rd_addr     (rd_slot_q.addr),
  .retry       (retry_q),
  .out_cnt     (out_cnt),
  .wb_cnt      (wb_cnt),
  .wb_overflow (wb_overflow),
  .done        (done)
);

// File: tb/test_pws_walk_sched.sv
`timescale 1ns/1ps
module test_pws_walk_sched;
  import pws_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              rd_enq_valid = 0, wr_enq_valid = 0, wk_fault = 0;
  logic [PA_W-1:0]   rd_enq_addr = '0, wr_enq_addr = '0, rsp_addr = '0;
  logic [SZ_W-1:0]   rd_enq_size = 4'd8, wr_enq_size = 4'd8, rsp_size = 4'd8;
  logic [DATA_W-1:0] wr_enq_data = '0, rsp_data = '0;
  logic              mreq_ready = 0, mreq_retry = 0;
  logic              rsp_valid = 0, rsp_nack = 0, rsp_we = 0;
  logic              wk_rsp_valid, mreq_valid, mreq_we, done, done_fault, wb_overflow;
  logic [DATA_W-1:0] wk_rsp_data, mreq_data;
  logic [PA_W-1:0]   mreq_addr;
  logic [SZ_W-1:0]   mreq_size;

  pws_walk_sched i_pws_walk_sched (
    .clk(clk), .rst_n(rst_n),
    .rd_enq_valid(rd_enq_valid), .rd_enq_addr(rd_enq_addr), .rd_enq_size(rd_enq_size),
    .wr_enq_valid(wr_enq_valid), .wr_enq_addr(wr_enq_addr), .wr_enq_data(wr_enq_data),
    .wr_enq_size(wr_enq_size), .wk_fault(wk_fault),
    .wk_rsp_valid(wk_rsp_valid), .wk_rsp_data(wk_rsp_data),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
    .mreq_we(mreq_we), .mreq_data(mreq_data), .mreq_size(mreq_size), .mreq_retry(mreq_retry),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_we(rsp_we), .rsp_addr(rsp_addr),
    .rsp_data(rsp_data), .rsp_size(rsp_size),
    .done(done), .done_fault(done_fault), .wb_overflow(wb_overflow)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Scoreboard of requests expected to be accepted, in order
  typedef struct {
    logic [PA_W-1:0]   addr;
    logic              we;
    logic [DATA_W-1:0] data;
    string             tag;
  } exp_t;
  exp_t exp_q[$];
  exp_t mon_e;

  task automatic expect_req(logic [PA_W-1:0] a, logic we, logic [DATA_W-1:0] d, string tag);
    exp_t e;
    e.addr = a; e.we = we; e.data = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  always begin
    @(negedge clk);
    #2;
    if (rst_n && mreq_valid && mreq_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected request addr", 64'(mreq_addr), 64'h0);
      end else begin
        mon_e = exp_q.pop_front();
        chk(mreq_addr == mon_e.addr, mon_e.tag, "request addr", 64'(mreq_addr), 64'(mon_e.addr));
        chk(mreq_we == mon_e.we, mon_e.tag, "request we", 64'(mreq_we), 64'(mon_e.we));
        if (mon_e.we)
          chk(mreq_data == mon_e.data, mon_e.tag, "request data", mreq_data, mon_e.data);
      end
    end
  end

  // Advance to the next cycle and clear all one-cycle inputs
  task automatic nxt();
    @(negedge clk);
    rd_enq_valid = 0; wr_enq_valid = 0; wk_fault = 0;
    rsp_valid = 0; rsp_nack = 0; rsp_we = 0; mreq_retry = 0;
  endtask

  task automatic give_rsp(logic [PA_W-1:0] a, logic we, logic nack, logic [DATA_W-1:0] d);
    rsp_valid = 1; rsp_addr = a; rsp_we = we; rsp_nack = nack; rsp_data = d; rsp_size = 4'd8;
  endtask

  task automatic push_wb(logic [PA_W-1:0] a, logic [DATA_W-1:0] d);
    wr_enq_valid = 1; wr_enq_addr = a; wr_enq_data = d;
  endtask

  task automatic push_rd(logic [PA_W-1:0] a);
    rd_enq_valid = 1; rd_enq_addr = a;
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // ---------------- reset
    repeat (3) @(negedge clk);
    #2;
    chk(mreq_valid == 0 && done == 0 && done_fault == 0 && wb_overflow == 0, "R1",
        "outputs in reset", {mreq_valid, done, done_fault, wb_overflow}, 0);
    rst_n = 1;
    nxt(); #2;
    chk(mreq_valid == 0 && done == 0 && wb_overflow == 0, "R1", "outputs after reset",
        {mreq_valid, done, wb_overflow}, 0);

    // ---------------- two-level walk, port always ready
    mreq_ready = 1;
    nxt(); push_rd('h1000); expect_req('h1000, 0, 0, "R2");
    nxt(); #2 chk(done == 0, "R9", "done during walk", done, 0);
    nxt(); give_rsp('h1000, 0, 0, 64'h11); push_rd('h2000); push_wb('h1000, 64'h31);
    expect_req('h2000, 0, 0, "R2");
    expect_req('h1000, 1, 64'h31, "R2");
    #2 chk(wk_rsp_valid == 1 && wk_rsp_data == 64'h11, "R8", "read forwarded",
           {wk_rsp_valid, wk_rsp_data[7:0]}, {1'b1, 8'h11});
    nxt();                              // read 0x2000 ahead of the write-back
    nxt();                              // write-back 0x1000
    nxt(); give_rsp('h2000, 0, 0, 64'h22); push_wb('h2000, 64'h42);
    expect_req('h2000, 1, 64'h42, "R3");
    #2 chk(wk_rsp_data == 64'h22, "R8", "second read data", wk_rsp_data, 64'h22);
    nxt();                              // write-back 0x2000
    nxt(); give_rsp('h1000, 1, 0, 0);
    #2 chk(wk_rsp_valid == 0, "R8", "write response not forwarded", wk_rsp_valid, 0);
    chk(done == 0, "R5", "done with requests outstanding", done, 0);
    nxt(); give_rsp('h2000, 1, 0, 0);
    #2 chk(done == 0, "R5", "done with one outstanding", done, 0);
    nxt(); #2 chk(done == 1 && done_fault == 0, "R9", "walk complete", {done, done_fault}, 2'b10);
    nxt(); #2 chk(done == 0, "R9", "done one cycle", done, 0);

    // ---------------- rejection, freeze, stack fill and overflow
    mreq_ready = 0;
    nxt(); push_rd('h3000);
    nxt(); push_wb('h3108, 64'hA1);
    #2 chk(mreq_valid == 1 && mreq_we == 0, "R4", "read offered then rejected",
           {mreq_valid, mreq_we}, 2'b10);
    for (int i = 2; i <= 4; i++) begin
      nxt(); push_wb(PA_W'('h3100 + i * 8), 64'(8'hA0 + i));
      #2 chk(mreq_valid == 0, "R4", "frozen after reject", mreq_valid, 0);
    end
    nxt(); push_wb('h3500, 64'hEE);
    #2 chk(wb_overflow == 1, "R10", "push onto full stack", wb_overflow, 1);
    chk(mreq_valid == 0, "R4", "frozen while stack full", mreq_valid, 0);
    nxt(); mreq_ready = 1;
    #2 chk(mreq_valid == 0, "R4", "ready alone does not unfreeze", mreq_valid, 0);
    chk(wb_overflow == 0, "R10", "overflow single cycle", wb_overflow, 0);
    nxt(); mreq_retry = 1;
    expect_req('h3000, 0, 0, "R4");
    for (int i = 4; i >= 1; i--) expect_req(PA_W'('h3100 + i * 8), 1, 64'(8'hA0 + i), "R3");
    #2 chk(mreq_valid == 0, "R4", "retry cycle itself idle", mreq_valid, 0);
    repeat (5) nxt();                   // read then W4..W1
    nxt(); give_rsp('h3000, 0, 0, 64'h33); wk_fault = 1;
    for (int i = 4; i >= 1; i--) begin
      nxt(); give_rsp(PA_W'('h3100 + i * 8), 1, 0, 0);
      #2 chk(done == 0, "R5", "writes still outstanding", done, 0);
    end
    nxt(); #2 chk(done == 1 && done_fault == 1, "R9", "faulted walk complete",
                  {done, done_fault}, 2'b11);
    chk(exp_q.size() == 0, "R10", "overflowed entry never issued", exp_q.size(), 0);
    nxt(); #2 chk(done == 0, "R9", "done one cycle", done, 0);

    // ---------------- negative acknowledges
    nxt(); push_rd('h4000); expect_req('h4000, 0, 0, "R6");
    nxt();                              // read accepted
    nxt(); give_rsp('h4000, 0, 1, 0); expect_req('h4000, 0, 0, "R6");
    #2 chk(mreq_valid == 1 && mreq_addr == 'h4000 && mreq_we == 0, "R6", "immediate resend",
           64'(mreq_addr), 64'h4000);
    chk(wk_rsp_valid == 0, "R8", "nack not forwarded", wk_rsp_valid, 0);
    nxt(); mreq_ready = 0; give_rsp('h4000, 0, 1, 0);
    #2 chk(mreq_valid == 1, "R7", "resend offered", mreq_valid, 1);
    nxt(); mreq_ready = 1;
    #2 chk(mreq_valid == 0 && done == 0, "R7", "read back in slot, frozen",
           {mreq_valid, done}, 0);
    nxt(); mreq_retry = 1; expect_req('h4000, 0, 0, "R7");
    nxt();                              // read reissued
    nxt(); give_rsp('h4000, 0, 0, 64'h44); push_wb('h4000, 64'h64);
    expect_req('h4000, 1, 64'h64, "R3");
    nxt();                              // write-back accepted
    nxt(); mreq_ready = 0; give_rsp('h4000, 1, 1, 64'h64);
    #2 chk(mreq_valid == 1 && mreq_we == 1 && mreq_data == 64'h64, "R7", "write resend offered",
           mreq_data, 64'h64);
    nxt(); mreq_ready = 1;
    #2 chk(mreq_valid == 0 && done == 0, "R7", "write back on stack, frozen",
           {mreq_valid, done}, 0);
    nxt(); mreq_retry = 1; expect_req('h4000, 1, 64'h64, "R7");
    nxt();                              // write-back reissued
    nxt(); give_rsp('h4000, 1, 0, 0);
    nxt(); #2 chk(done == 1 && done_fault == 0, "R9", "fault record cleared",
                  {done, done_fault}, 2'b10);
    nxt();
    chk(exp_q.size() == 0, "R3", "all expected requests seen", exp_q.size(), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule